// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block drives the serial line of a LIN bus master for the header part of a frame. A one-cycle start request launches a fixed sequence. An idle character is sent first when that option is enabled. The break field follows, then the sync character, then the protected identifier character. After the identifier's stop bit the line returns to recessive and the block raises a one-cycle completion pulse. The two sync-style characters are standard UART characters: one start bit, eight data bits sent least significant bit first, and one stop bit.

Bit timing comes from a divider value multiplied by sixteen system clocks. The bit timer restarts on the clock edge that accepts a request, so the first low bit of the break always has its full length. The optional idle character lets system software enforce a recessive gap before the break without any timing side effect. The divider, the identifier and the idle option are captured when a request is accepted, and changes to them during a header are ignored.

States: `ST_IDLE` (waiting, line high), `ST_PREIDLE` (10 recessive bit times), `ST_BREAK` (13 dominant bit times), `ST_DELIM` (1 recessive bit time), `ST_SYNC` (sync character), `ST_PID` (identifier character). The transitions are as follows:
- An accepted start moves `ST_IDLE` to `ST_PREIDLE` when idle-before-break is set, and to `ST_BREAK` otherwise.
- Each of the other states moves to the next state in the list above on the bit tick that ends its last bit.
- `ST_PID` returns to `ST_IDLE` and fires the done pulse.

Top module: `lin_hdr_tx`

## Requirements
- R1: Out of reset, and at all times while not busy, `tx` is 1 (recessive) and `busy` is 0.
- R2: One bit time lasts `div`×16 clock cycles, and a `div` of 0 acts as 1. `div` is captured when a request is accepted.
- R3: The break field is 13 bit times of `tx`=0 followed by a 1-bit-time delimiter at `tx`=1.
- R4: The sync character is a 0 start bit, then byte 0x55 least significant bit first, then a 1 stop bit.
- R5: The identifier character is a 0 start bit, then a protected byte sent least significant bit first, then a 1 stop bit. In the protected byte, bits 5..0 = id[5:0], bit 6 = id0^id1^id2^id4, and bit 7 = ~(id1^id3^id4^id5). Input bits id[7:6] are not used.
- R6: Without the idle option, break, delimiter, sync and identifier follow each other with no gap. The header therefore lasts exactly 34 bit times, measured from the accepting clock edge to the edge on which `busy` falls.
- R7: With `idle_en`=1 at acceptance, 10 bit times of `tx`=1 come before the break, and the header lasts exactly 44 bit times.
- R8: A `start` pulse while `busy` is 1 is ignored, and the header in progress continues unchanged.
- R9: `busy` rises on the edge after `start` is seen while not busy. It stays high until the header ends. `done` is high for exactly one cycle, in the cycle in which `busy` has just fallen.
- R10: `id` and `idle_en` are captured at acceptance, and later changes during the header do not alter the transmitted bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle header request |
| idle_en | input | 1 | Send a recessive idle character before the break |
| id | input | 8 | Frame identifier; bits 5..0 are used |
| div | input | DIV_W | Baud divider; bit time = div×16 clocks |
| busy | output | 1 | Header in progress |
| done | output | 1 | One-cycle pulse when the header has ended |
| tx | output | 1 | Serial line output, high when recessive |

## Verification
The hardest case to reach from the ports is a second request, or a change of identifier, divider or idle option, that lands in the middle of a header. In that case the line must still carry the originally captured header at the originally captured bit rate. The bench reaches this case by pulsing `start` about a hundred cycles into a header while inverting the identifier and the idle option and raising the divider. It then checks every cycle of the line against the header expected from the first request. Exact per-cycle checking at two divider values, and at a divider of zero, pins the bit length and the absence of gaps.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREIDLE,
        ST_BREAK,
        ST_DELIM,
        ST_SYNC,
        ST_PID
    } hdr_state_t;

    localparam int          OVS        = 16;
    localparam int          IDLE_BITS  = 10;
    localparam int          BRK_BITS   = 13;
    localparam int          DELIM_BITS = 1;
    localparam int          CHAR_BITS  = 10;
    localparam logic [7:0]  SYNC_BYTE  = 8'h55;
endpackage

// File: rtl/lin_baud_gen.sv
module lin_baud_gen #(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CW = DIV_W + $clog2(OVS) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_m1;
    logic [DIV_W-1:0] eff;

    always_comb begin
        eff    = (div == '0) ? DIV_W'(1) : div;
        lim_m1 = CW'(eff) * CW'(OVS) - CW'(1);
    end

    assign tick = (cnt == lim_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/lin_pid_calc.sv
module lin_pid_calc (
    input  logic [5:0] ident,
    output logic [7:0] pid
);
    logic par_even;
    logic par_odd;

    always_comb begin
        par_even = ident[0] ^ ident[1] ^ ident[2] ^ ident[4];
        par_odd  = ~(ident[1] ^ ident[3] ^ ident[4] ^ ident[5]);
        pid      = {par_odd, par_even, ident};
    end
endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
    import lin_hdr_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             idle_en,
    input  logic [7:0]       id,
    input  logic [DIV_W-1:0] div,
    output logic             busy,
    output logic             done,
    output logic             tx
);
    hdr_state_t       state, nxt;
    logic [3:0]       bitcnt;
    logic [5:0]       id_q;
    logic [DIV_W-1:0] div_q;
    logic             bit_tick;
    logic             accept;
    logic             last_bit;
    logic [3:0]       last_idx;
    logic [7:0]       pid_byte;
    logic [9:0]       sync_frame;
    logic [9:0]       pid_frame;

    assign accept = (state == ST_IDLE) && start;

    lin_baud_gen #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state == ST_IDLE),
        .div     (div_q),
        .tick    (bit_tick)
    );

    lin_pid_calc u_pid (
        .ident (id_q),
        .pid   (pid_byte)
    );

    assign sync_frame = {1'b1, SYNC_BYTE, 1'b0};
    assign pid_frame  = {1'b1, pid_byte, 1'b0};

    // last bit index of each state
    always_comb begin
        unique case (state)
            ST_PREIDLE: last_idx = 4'(IDLE_BITS - 1);
            ST_BREAK:   last_idx = 4'(BRK_BITS - 1);
            ST_DELIM:   last_idx = 4'(DELIM_BITS - 1);
            ST_SYNC,
            ST_PID:     last_idx = 4'(CHAR_BITS - 1);
            default:    last_idx = 4'd0;
        endcase
        last_bit = bit_tick && (bitcnt == last_idx);
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = idle_en ? ST_PREIDLE : ST_BREAK;
            ST_PREIDLE: if (last_bit) nxt = ST_BREAK;
            ST_BREAK:   if (last_bit) nxt = ST_DELIM;
            ST_DELIM:   if (last_bit) nxt = ST_SYNC;
            ST_SYNC:    if (last_bit) nxt = ST_PID;
            ST_PID:     if (last_bit) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            id_q   <= '0;
            div_q  <= '0;
            done   <= 1'b0;
        end else begin
            state <= nxt;
            done  <= (state == ST_PID) && last_bit;
            if (accept) begin
                id_q   <= id[5:0];
                div_q  <= div;
                bitcnt <= '0;
            end else if (last_bit) begin
                bitcnt <= '0;
            end else if (bit_tick) begin
                bitcnt <= bitcnt + 4'd1;
            end
        end
    end

    // outputs
    always_comb begin
        busy = 1'b1;
        tx   = 1'b1;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_PREIDLE: tx   = 1'b1;
            ST_BREAK:   tx   = 1'b0;
            ST_DELIM:   tx   = 1'b1;
            ST_SYNC:    tx   = sync_frame[bitcnt];
            ST_PID:     tx   = pid_frame[bitcnt];
            default:    tx   = 1'b1;
        endcase
    end
endmodule

// File: rtl/lin_hdr_tx_chk.sv
module lin_hdr_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic tx,
    input logic tick
);
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_at_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_fall_gives_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_bit_edges_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(tick)) |-> $stable(tx));

    p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !tick) |=> busy);
endmodule

bind lin_hdr_tx lin_hdr_tx_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .tx    (tx),
    .tick  (bit_tick)
);

// File: tb/sim_lin_hdr_tx.sv
module sim_lin_hdr_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        idle_en = 1'b0;
    logic [7:0]  id = 8'h00;
    logic [15:0] div = 16'd1;
    logic        busy, done, tx;

    int n_chk  = 0;
    int n_fail = 0;

    lin_hdr_tx #(.DIV_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .idle_en(idle_en),
        .id(id), .div(div), .busy(busy), .done(done), .tx(tx)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit [7:0] prot(input bit [7:0] i);
        bit p0, p1;
        p0 = i[0] ^ i[1] ^ i[2] ^ i[4];
        p1 = ~(i[1] ^ i[3] ^ i[4] ^ i[5]);
        return {p1, p0, i[5:0]};
    endfunction

    function automatic bit exp_bit(input bit [7:0] i, input bit ien, input int b);
        int k;
        bit [9:0] sf, pf;
        sf = {1'b1, 8'h55, 1'b0};
        pf = {1'b1, prot(i), 1'b0};
        k  = ien ? b - 10 : b;
        if (k < 0)  return 1'b1;
        if (k < 13) return 1'b0;
        if (k == 13) return 1'b1;
        if (k < 24) return sf[k-14];
        return pf[k-24];
    endfunction

    function automatic string bit_req(input bit ien, input int b);
        int k;
        k = ien ? b - 10 : b;
        if (k < 0)  return "R7";
        if (k < 14) return "R3";
        if (k < 24) return "R4";
        return "R5";
    endfunction

    // one header, compared on every clock cycle; optional mid-header disturbance
    task automatic run_hdr(input bit [7:0] i, input bit ien, input bit [15:0] d,
                           input bit disturb, input string tag);
        int  tb;
        int  nb;
        bit  bad;
        bit  busy_bad;
        tb = ((d == 0) ? 1 : int'(d)) * 16;
        nb = ien ? 44 : 34;
        @(negedge clk);
        id = i; idle_en = ien; div = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bad = 1'b0;
        busy_bad = 1'b0;
        for (int c = 0; c < nb * tb; c++) begin
            if (c > 0) @(negedge clk);
            if (tx !== exp_bit(i, ien, c / tb)) bad = 1'b1;
            if (busy !== 1'b1) busy_bad = 1'b1;
            if (disturb && c == 100) begin
                // R8 R10: new request and changed inputs mid-header
                start = 1'b1; id = ~i; idle_en = ~ien; div = d + 16'd3;
            end
            if (disturb && c == 101) start = 1'b0;
            if (c % tb == tb - 1) begin
                chk(!bad, disturb ? "R10" : bit_req(ien, c / tb),
                    $sformatf("%s bit %0d", tag, c / tb), int'(tx),
                    int'(exp_bit(i, ien, c / tb)));
                bad = 1'b0;
            end
        end
        chk(!busy_bad, disturb ? "R8" : "R9", {tag, " busy during header"}, 0, 1);
        @(negedge clk);
        chk(busy === 1'b0, ien ? "R7" : "R6", {tag, " busy falls at header end"},
            int'(busy), 0);
        chk(done === 1'b1, "R9", {tag, " done pulse"}, int'(done), 1);
        chk(tx === 1'b1, "R1", {tag, " line recessive after"}, int'(tx), 1);
        @(negedge clk);
        chk(done === 1'b0, "R9", {tag, " done one cycle"}, int'(done), 0);
        idle_en = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(tx === 1'b1, "R1", "reset tx", int'(tx), 1);
        chk(busy === 1'b0, "R1", "reset busy", int'(busy), 0);
        chk(done === 1'b0, "R9", "reset done", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(tx === 1'b1 && busy === 1'b0, "R1", "idle after reset", int'(tx), 1);
    endtask

    task automatic t_plain();        run_hdr(8'h00, 1'b0, 16'd1, 1'b0, "plain id00 R6");  endtask
    task automatic t_patterns();
        run_hdr(8'h3F, 1'b0, 16'd2, 1'b0, "id3F div2 R2");
        run_hdr(8'hEA, 1'b0, 16'd1, 1'b0, "idEA upper ignored R5");
    endtask
    task automatic t_idle();         run_hdr(8'h15, 1'b1, 16'd1, 1'b0, "idle first R7");  endtask
    task automatic t_div_zero();     run_hdr(8'h07, 1'b0, 16'd0, 1'b0, "div0 R2");        endtask
    task automatic t_disturb();
        run_hdr(8'h2C, 1'b0, 16'd1, 1'b1, "disturb R8");
        run_hdr(8'h11, 1'b1, 16'd2, 1'b1, "disturb idle R10");
    endtask

    initial begin
        t_reset();
        t_plain();
        t_patterns();
        t_idle();
        t_div_zero();
        t_disturb();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule